// File: doc/BRIEF.md
# Configuration master clock generator

This block produces the configuration clock that a device drives out to its serial storage device and to any downstream slave devices when its mode straps select master operation. It divides the on-chip oscillator by a parameterised ratio so that the output starts at a default rate. With the default parameters and a 100 MHz oscillator, that default rate is 2.5 MHz. In any other strap setting the clock pad is left undriven, because the clock then comes in from outside.

Early in the bitstream, the configuration logic presents a rate-select code together with a load strobe. The block holds that request as pending and applies it only at the end of a full low phase, so no high or low phase is ever cut short. Once the external DONE signal rises, the clock keeps running for a fixed number of further cycles and then parks low. That number is a parameter, and elaboration rejects any value outside 100 to 500.

Top module: `cfg_mclk_gen`

## Requirements
- R1: `cclk_oe` is 1 one oscillator cycle after `mode_pins` equals 2'b01 (master), and is 0 one cycle after `mode_pins` takes any other value. While `cclk_oe` is 0, `cclk_o` is 0.
- R2: After reset in master mode, with no load, every high phase and every low phase of `cclk_o` lasts DEF_HALF oscillator cycles (default 20).
- R3: A pulse on `freq_load` with code k on `freq_sel` (2 bits) selects a half period of max(1, DEF_HALF >> k) oscillator cycles. With the defaults, codes 0, 1, 2 and 3 give 20, 10, 5 and 2.
- R4: A new ratio takes effect only at a low-to-high transition. Each phase therefore lasts either the old length or the new length, and every low phase has the same length as the high phase before it.
- R5: Without a load the default ratio stays in force, and reset restores the default ratio even after a load.
- R6: Once `done_in` is high, the block takes it through two synchronising flops. It then gives exactly RUNON (default 100) further falling edges on `cclk_o`, after which `cclk_o` stays 0 while `cclk_oe` stays 1.
- R7: When the part returns to master mode after leaving it, the clock restarts from low and keeps the ratio that was in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pins | input | 2 | Mode straps; 2'b01 selects master |
| freq_sel | input | 2 | Rate-select code |
| freq_load | input | 1 | One-cycle strobe that captures `freq_sel` |
| done_in | input | 1 | External DONE, asynchronous |
| cclk_o | output | 1 | Configuration clock |
| cclk_oe | output | 1 | Output enable for the clock pad |

## Verification
The hardest case to create is a rate change that lands at an arbitrary point inside a phase. Only then can a careless design produce a runt phase. The stimulus therefore loads random codes after random delays and checks that every phase around the change has either the old length or the new length.

The post-DONE count is checked exactly. To make it exact, DONE is raised just after an observed falling edge, so that the synchroniser delay cannot move a falling edge across the start of the count.

// File: rtl/cfg_mclk_pkg.sv
package cfg_mclk_pkg;
  localparam logic [1:0] MODE_MASTER = 2'b01;

  // Half period, in oscillator cycles, selected by a rate code.
  function automatic int half_of(input int code, input int def_half);
    int h;
    h = def_half >> code;
    if (h < 1) h = 1;
    return h;
  endfunction
endpackage

// File: rtl/cfg_done_sync.sv
module cfg_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) sr[0] <= 1'b0;
        else     sr[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) sr[i] <= 1'b0;
        else     sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/cfg_rate_div.sv
module cfg_rate_div #(
  parameter int DEF_HALF = 20,
  localparam int CNT_W = $clog2(DEF_HALF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pend_vld,
  input  logic [CNT_W-1:0] pend_half,
  output logic             cclk,
  output logic             take,
  output logic             fall_ev,
  output logic [CNT_W-1:0] half_cur
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap    = en && (cnt == half_cur - 1'b1);
  assign take    = wrap && !cclk && pend_vld;
  assign fall_ev = wrap && cclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cclk     <= 1'b0;
      half_cur <= CNT_W'(DEF_HALF);
    end else if (!en) begin
      cnt  <= '0;
      cclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      cclk <= ~cclk;
      if (take) half_cur <= pend_half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_runon_ctr.sv
module cfg_runon_ctr #(
  parameter int RUNON = 100,
  localparam int RUN_W = $clog2(RUNON + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic done_s,
  input  logic fall_ev,
  output logic stopped,
  output logic [RUN_W-1:0] n_falls
);
  always_ff @(posedge clk) begin
    if (rst) begin
      n_falls <= '0;
      stopped <= 1'b0;
    end else if (done_s && !stopped && fall_ev) begin
      n_falls <= n_falls + 1'b1;
      if (n_falls == RUN_W'(RUNON - 1)) stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_mclk_gen.sv
module cfg_mclk_gen #(
  parameter int DEF_HALF = 20,
  parameter int SEL_W    = 2,
  parameter int RUNON    = 100,
  localparam int CNT_W   = $clog2(DEF_HALF + 1),
  localparam int RUN_W   = $clog2(RUNON + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_pins,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             freq_load,
  input  logic             done_in,
  output logic             cclk_o,
  output logic             cclk_oe
);
  import cfg_mclk_pkg::*;

  if (RUNON < 100 || RUNON > 500) begin : g_bad_runon
    $error("RUNON must lie within 100..500");
  end

  logic             is_master;
  logic             done_s;
  logic             stopped;
  logic             en;
  logic             take;
  logic             fall_ev;
  logic             pend_vld;
  logic [CNT_W-1:0] pend_half;
  logic [CNT_W-1:0] half_cur;
  logic [RUN_W-1:0] n_falls;
  logic             oe_q;

  assign is_master = (mode_pins == MODE_MASTER);
  assign en        = is_master && !stopped;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_half <= CNT_W'(DEF_HALF);
    end else if (freq_load) begin
      pend_vld  <= 1'b1;
      pend_half <= CNT_W'(half_of(int'(freq_sel), DEF_HALF));
    end else if (take) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) oe_q <= is_master;

  cfg_done_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(done_in), .q(done_s)
  );

  cfg_rate_div #(.DEF_HALF(DEF_HALF)) u_div (
    .clk(clk), .rst(rst), .en(en), .pend_vld(pend_vld),
    .pend_half(pend_half), .cclk(cclk_o), .take(take),
    .fall_ev(fall_ev), .half_cur(half_cur)
  );

  cfg_runon_ctr #(.RUNON(RUNON)) u_run (
    .clk(clk), .rst(rst), .done_s(done_s), .fall_ev(fall_ev),
    .stopped(stopped), .n_falls(n_falls)
  );

  assign cclk_oe = oe_q;
endmodule

// File: rtl/cfg_mclk_chk.sv
module cfg_mclk_chk #(
  parameter int CNT_W = 5,
  parameter int RUN_W = 7,
  parameter int RUNON = 100
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_pins,
  input logic             cclk_o,
  input logic             cclk_oe,
  input logic             stopped,
  input logic [CNT_W-1:0] half_cur,
  input logic [RUN_W-1:0] n_falls
);
  p_oe_follows_mode_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cclk_oe == ($past(mode_pins) == 2'b01)));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !cclk_oe |-> !cclk_o);

  p_ratio_at_rise_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(half_cur) |-> $rose(cclk_o));

  p_parked_low_r6: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !cclk_o);

  p_stays_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    stopped |=> stopped);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    n_falls <= RUN_W'(RUNON));
endmodule

bind cfg_mclk_gen cfg_mclk_chk #(.CNT_W(CNT_W), .RUN_W(RUN_W), .RUNON(RUNON)) u_chk (
  .clk(clk), .rst(rst), .mode_pins(mode_pins), .cclk_o(cclk_o),
  .cclk_oe(cclk_oe), .stopped(stopped), .half_cur(half_cur), .n_falls(n_falls)
);

// File: tb/sim_cfg_mclk_gen.sv
module sim_cfg_mclk_gen;
  localparam int DEF_HALF = 20;
  localparam int RUNON    = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_pins = 2'b01;
  logic [1:0] freq_sel  = 2'b00;
  logic       freq_load = 1'b0;
  logic       done_in   = 1'b0;
  logic       cclk_o, cclk_oe;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  always #2 clk = ~clk;

  cfg_mclk_gen #(.DEF_HALF(DEF_HALF), .SEL_W(2), .RUNON(RUNON)) u0 (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .freq_sel(freq_sel),
    .freq_load(freq_load), .done_in(done_in), .cclk_o(cclk_o), .cclk_oe(cclk_oe)
  );

  function automatic int exp_half(input int code);
    int h;
    h = DEF_HALF >> code;
    return (h < 1) ? 1 : h;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic phase_len(output int len);
    logic v;
    v = cclk_o;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (cclk_o == v && len < 1000);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input int code);
    @(negedge clk);
    freq_sel  = 2'(code);
    freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
  endtask

  task automatic measure(input string req, input int n, input int exp);
    int l;
    phase_len(l);
    for (int i = 0; i < n; i++) begin
      phase_len(l);
      check(req, l, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int l, l2, old_h, new_h, code, falls, quiet;
    logic prev;
    seed_dummy = $urandom(32'd1234);

    do_reset();
    @(negedge clk);
    // R1 / R2 reset state
    check("R1 oe after reset", int'(cclk_oe), 1);
    check("R2 low after reset", int'(cclk_o), 0);
    measure("R2 default half", 4, DEF_HALF);

    // R1 / R7 non-master mode
    mode_pins = 2'b00;
    repeat (2) @(negedge clk);
    check("R1 oe in slave", int'(cclk_oe), 0);
    l = 0;
    repeat (100) begin
      @(negedge clk);
      if (cclk_o) l++;
    end
    check("R1 clock low in slave", l, 0);
    mode_pins = 2'b11;
    repeat (2) @(negedge clk);
    check("R1 oe in mode 11", int'(cclk_oe), 0);
    mode_pins = 2'b01;
    @(negedge clk);
    check("R7 restart low", int'(cclk_o), 0);
    measure("R7 ratio kept", 3, DEF_HALF);

    // R3 directed codes
    for (int c = 0; c < 4; c++) begin
      load(c);
      phase_len(l); phase_len(l); phase_len(l);
      measure("R3 code half", 4, exp_half(c));
    end

    // R4 random loads at random points
    old_h = exp_half(3);
    for (int it = 0; it < 20; it++) begin
      code = int'($urandom_range(0, 3));
      repeat ($urandom_range(0, 30)) @(negedge clk);
      load(code);
      new_h = exp_half(code);
      phase_len(l);
      for (int k = 0; k < 3; k++) begin
        phase_len(l);
        check("R4 phase old or new", int'(l == old_h || l == new_h), 1);
      end
      phase_len(l);
      phase_len(l2);
      check("R4 settled", l, new_h);
      check("R4 low equals high", l2, l);
      old_h = new_h;
    end

    // R4 equal-phase check around a change from 20 to 5
    do_reset();
    @(negedge clk);
    while (cclk_o != 1'b1) @(negedge clk);
    load(2);
    phase_len(l);
    phase_len(l);
    check("R4 low keeps old ratio", l, DEF_HALF);
    phase_len(l);
    check("R4 high takes new ratio", l, 5);

    // R5 reset restores default, default persists without load
    do_reset();
    measure("R5 default after reset", 6, DEF_HALF);

    // R6 run-on after DONE
    load(1);
    phase_len(l); phase_len(l); phase_len(l);
    while (cclk_o != 1'b1) @(negedge clk);
    while (cclk_o != 1'b0) @(negedge clk);
    done_in = 1'b1;
    falls = 0;
    quiet = 0;
    prev  = cclk_o;
    while (quiet < 200) begin
      @(negedge clk);
      if (prev && !cclk_o) begin
        falls++;
        quiet = 0;
      end else begin
        quiet++;
      end
      prev = cclk_o;
    end
    check("R6 falls after done", falls, RUNON);
    l = 0;
    repeat (300) begin
      @(negedge clk);
      if (cclk_o) l++;
    end
    check("R6 parked low", l, 0);
    check("R6 oe kept", int'(cclk_oe), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule